// File: doc/BRIEF.md
# Serial Receive Status Flags

This block keeps the receive-side status flags of a serial port that runs either in a clocked 8-bit mode or in one of three asynchronous character formats. The receive shifter is not part of the block. It reports each finished character with a single strobe and four decoded attributes: whether the stop bit was good, whether the parity matched, the value of the ninth bit, and whether the character overran an unread one. The block decides whether that character may enter the receive data register, and it drives `rxLoad` to say so. It then records the error and address information that goes with the character.

Software sees one read-only status word. The error flags behave like sticky bits. They clear only when a read of the status register is later followed by a read of the data register. A framing error also locks the data register against further loads until that read sequence has run. An overrun hides any framing or parity error on the same character. Three line-state bits from the transmitter and the line monitor are shown in the same word without change. Any of three synchronous sources (software reset, port reset, stop command) or the asynchronous hardware reset returns every held flag to zero.

Top module: `rx_status_flags`

## Requirements
- R1: After hardware reset (rstN low) every held flag (R8, FE, PE, OR, RDRF) and the read tracker are zero, so the status word shows only the line-state inputs.
- R2: The status word layout is bit 7 R8, bit 6 FE, bit 5 PE, bit 4 OR, bit 3 idleIn, bit 2 RDRF, bit 1 txEmptyIn, bit 0 txDoneIn. Bits STATUS_W-1 down to 8 always read zero. The three line-state bits follow their inputs in the same cycle.
- R3: A wordValid strobe with overrun low while FE is clear and no reset source is active raises rxLoad in that same cycle. After that clock edge RDRF is 1.
- R4: On a load, FE becomes 1 when stopOk is 0 and modeSel is 1, 2 or 3 (the asynchronous modes). In modeSel 0 (8-bit synchronous) FE stays 0.
- R5: On a load, PE becomes 1 only when modeSel is 2 (11-bit with parity) and parityOk is 0. In every other mode PE becomes 0.
- R6: On a load, R8 takes ninthBit when modeSel is 3 (multidrop: 1 = address, 0 = data) and 0 otherwise. Status reads and data reads leave R8 unchanged.
- R7: While FE is 1, a wordValid strobe gives rxLoad 0 and changes no flag. A set PE does not block later loads.
- R8: A wordValid strobe with overrun high sets OR, leaves FE, PE, R8 and RDRF unchanged, and gives rxLoad 0.
- R9: A dataRd pulse clears FE, PE and OR only if a statusRd pulse came after the previous dataRd. Each dataRd disarms that tracker.
- R10: A dataRd pulse clears RDRF unless a word is loaded in the same cycle.
- R11: When a word is loaded in the same cycle as a clearing dataRd, RDRF, FE, PE and R8 take the new word's values.
- R12: A pulse on softReset, unitReset or stopCmd clears R8, FE, PE, OR, RDRF and the tracker at the next edge, and it suppresses any load in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous hardware reset, active low |
| softReset | input | 1 | Software reset pulse |
| unitReset | input | 1 | Reset pulse for this serial port only |
| stopCmd | input | 1 | Stop / low-power command pulse |
| modeSel | input | 2 | 0 sync 8-bit, 1 async 10-bit, 2 async 11-bit parity, 3 async 11-bit multidrop |
| wordValid | input | 1 | Received-character strobe |
| stopOk | input | 1 | Stop bit was detected |
| parityOk | input | 1 | Parity bit matched |
| ninthBit | input | 1 | Received ninth bit |
| overrun | input | 1 | Character arrived while previous was unread |
| statusRd | input | 1 | Status register read strobe |
| dataRd | input | 1 | Receive data register read strobe |
| idleIn | input | 1 | Line idle indication |
| txEmptyIn | input | 1 | Transmit data register empty |
| txDoneIn | input | 1 | Transmitter fully empty |
| rxLoad | output | 1 | Permit to load the character into the data register |
| statusWord | output | STATUS_W | Read-only status word |

## Verification
The bench uses the default STATUS_W of 24, so sixteen reserved bits are compared against zero on every status check. Because the mode field has only two bits and each character has three attributes, the bench walks all 32 combinations of mode, stop bit, parity and ninth bit. Each combination is followed by the status-then-data clearing sequence. It also drives all eight line-state patterns. The ordering cases are run individually: blocking by FE, overrun precedence, a data read without an armed tracker, a load that coincides with a clearing read, and each of the three reset sources.

// File: rtl/rx_status_pkg.sv
package rx_status_pkg;

  typedef enum logic [1:0] {
    MODE_SYNC8     = 2'd0,
    MODE_ASYNC10   = 2'd1,
    MODE_ASYNC_PAR = 2'd2,
    MODE_MULTIDROP = 2'd3
  } rxMode_e;

  // strobes from control to the flag datapath
  typedef struct packed {
    logic load;     // character enters the data register
    logic setOvr;   // overrun character seen
    logic clrErr;   // armed data read clears error flags
    logic clrFull;  // data read empties the data register
    logic flush;    // any synchronous reset source
  } flagCtrl_t;

  localparam int BIT_TXDONE  = 0;
  localparam int BIT_TXEMPTY = 1;
  localparam int BIT_FULL    = 2;
  localparam int BIT_IDLE    = 3;
  localparam int BIT_OVR     = 4;
  localparam int BIT_PAR     = 5;
  localparam int BIT_FRAME   = 6;
  localparam int BIT_NINTH   = 7;
  localparam int LOW_W       = 8;

endpackage

// File: rtl/rx_status_ctrl.sv
module rx_status_ctrl
  import rx_status_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      softReset,
  input  logic      unitReset,
  input  logic      stopCmd,
  input  logic      wordValid,
  input  logic      overrun,
  input  logic      statusRd,
  input  logic      dataRd,
  input  logic      feHeld,
  output flagCtrl_t ctrl,
  output logic      rxLoad
);

  logic armed;
  logic flush;

  always_comb begin
    flush        = softReset | unitReset | stopCmd;
    ctrl.flush   = flush;
    ctrl.load    = wordValid & ~overrun & ~feHeld & ~flush;
    ctrl.setOvr  = wordValid & overrun & ~flush;
    ctrl.clrErr  = dataRd & armed;
    ctrl.clrFull = dataRd;
    rxLoad       = ctrl.load;
  end

  // status read arms, data read disarms; a simultaneous status read re-arms
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         armed <= 1'b0;
    else if (flush)    armed <= 1'b0;
    else if (statusRd) armed <= 1'b1;
    else if (dataRd)   armed <= 1'b0;
  end

endmodule

// File: rtl/rx_status_dp.sv
module rx_status_dp
  import rx_status_pkg::*;
#(
  parameter int STATUS_W = 24
) (
  input  logic                clk,
  input  logic                rstN,
  input  flagCtrl_t           ctrl,
  input  logic [1:0]          modeSel,
  input  logic                stopOk,
  input  logic                parityOk,
  input  logic                ninthBit,
  input  logic                idleIn,
  input  logic                txEmptyIn,
  input  logic                txDoneIn,
  output logic                feHeld,
  output logic [STATUS_W-1:0] statusWord
);

  localparam int HIGH_W = STATUS_W - LOW_W;

  rxMode_e mode;
  logic    isAsync, hasParity, isMultidrop;
  logic    fullQ, frameQ, parQ, ovrQ, ninthQ;

  always_comb begin
    mode        = rxMode_e'(modeSel);
    isAsync     = (mode != MODE_SYNC8);
    hasParity   = (mode == MODE_ASYNC_PAR);
    isMultidrop = (mode == MODE_MULTIDROP);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fullQ  <= 1'b0;
      frameQ <= 1'b0;
      parQ   <= 1'b0;
      ovrQ   <= 1'b0;
      ninthQ <= 1'b0;
    end else if (ctrl.flush) begin
      fullQ  <= 1'b0;
      frameQ <= 1'b0;
      parQ   <= 1'b0;
      ovrQ   <= 1'b0;
      ninthQ <= 1'b0;
    end else begin
      if (ctrl.load) begin
        fullQ  <= 1'b1;
        frameQ <= isAsync & ~stopOk;
        parQ   <= hasParity & ~parityOk;
        ninthQ <= isMultidrop & ninthBit;
      end else begin
        if (ctrl.clrFull) fullQ <= 1'b0;
        if (ctrl.clrErr) begin
          frameQ <= 1'b0;
          parQ   <= 1'b0;
        end
      end
      if (ctrl.setOvr)      ovrQ <= 1'b1;
      else if (ctrl.clrErr) ovrQ <= 1'b0;
    end
  end

  assign feHeld = frameQ;

  logic [LOW_W-1:0] lowByte;
  always_comb begin
    lowByte              = '0;
    lowByte[BIT_NINTH]   = ninthQ;
    lowByte[BIT_FRAME]   = frameQ;
    lowByte[BIT_PAR]     = parQ;
    lowByte[BIT_OVR]     = ovrQ;
    lowByte[BIT_IDLE]    = idleIn;
    lowByte[BIT_FULL]    = fullQ;
    lowByte[BIT_TXEMPTY] = txEmptyIn;
    lowByte[BIT_TXDONE]  = txDoneIn;
  end

  generate
    if (HIGH_W > 0) begin : g_wide
      assign statusWord = {{HIGH_W{1'b0}}, lowByte};
    end else begin : g_narrow
      assign statusWord = lowByte;
    end
  endgenerate

endmodule

// File: rtl/rx_status_flags.sv
module rx_status_flags
  import rx_status_pkg::*;
#(
  parameter int STATUS_W = 24
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                softReset,
  input  logic                unitReset,
  input  logic                stopCmd,
  input  logic [1:0]          modeSel,
  input  logic                wordValid,
  input  logic                stopOk,
  input  logic                parityOk,
  input  logic                ninthBit,
  input  logic                overrun,
  input  logic                statusRd,
  input  logic                dataRd,
  input  logic                idleIn,
  input  logic                txEmptyIn,
  input  logic                txDoneIn,
  output logic                rxLoad,
  output logic [STATUS_W-1:0] statusWord
);

  flagCtrl_t ctrl;
  logic      feHeld;

  rx_status_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .softReset(softReset), .unitReset(unitReset), .stopCmd(stopCmd),
    .wordValid(wordValid), .overrun(overrun),
    .statusRd(statusRd), .dataRd(dataRd),
    .feHeld(feHeld), .ctrl(ctrl), .rxLoad(rxLoad)
  );

  rx_status_dp #(.STATUS_W(STATUS_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .modeSel(modeSel), .stopOk(stopOk), .parityOk(parityOk), .ninthBit(ninthBit),
    .idleIn(idleIn), .txEmptyIn(txEmptyIn), .txDoneIn(txDoneIn),
    .feHeld(feHeld), .statusWord(statusWord)
  );

endmodule

// File: rtl/rx_status_flags_chk.sv
module rx_status_flags_chk #(
  parameter int STATUS_W = 24
) (
  input logic                clk,
  input logic                rstN,
  input logic                softReset,
  input logic                unitReset,
  input logic                stopCmd,
  input logic [1:0]          modeSel,
  input logic                wordValid,
  input logic                overrun,
  input logic                dataRd,
  input logic                rxLoad,
  input logic [STATUS_W-1:0] statusWord
);

  logic flush;
  assign flush = softReset | unitReset | stopCmd;

  p_load_sets_full_r3: assert property (@(posedge clk) disable iff (!rstN)
    rxLoad |=> statusWord[2]);

  p_sync_no_frame_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rxLoad && modeSel == 2'd0) |=> !statusWord[6]);

  p_parity_mode_only_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rxLoad && modeSel != 2'd2) |=> !statusWord[5]);

  p_ninth_holds_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!rxLoad && !flush) |=> $stable(statusWord[7]));

  p_frame_blocks_r7: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[6] |-> !rxLoad);

  p_overrun_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && overrun && !dataRd && !flush)
      |=> (statusWord[4] && $stable(statusWord[6]) && $stable(statusWord[5])));

  p_read_empties_r10: assert property (@(posedge clk) disable iff (!rstN)
    (dataRd && !rxLoad && !flush) |=> !statusWord[2]);

  p_flush_clears_r12: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (statusWord[7:4] == 4'b0 && !statusWord[2]));

endmodule

bind rx_status_flags rx_status_flags_chk #(.STATUS_W(STATUS_W)) u_chk (
  .clk(clk), .rstN(rstN), .softReset(softReset), .unitReset(unitReset),
  .stopCmd(stopCmd), .modeSel(modeSel), .wordValid(wordValid),
  .overrun(overrun), .dataRd(dataRd), .rxLoad(rxLoad), .statusWord(statusWord)
);

// File: tb/rx_status_flags_tb.sv
`timescale 1ns/1ps
module rx_status_flags_tb;

  localparam int SW = 24;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic softReset = 0, unitReset = 0, stopCmd = 0;
  logic [1:0] modeSel = 0;
  logic wordValid = 0, stopOk = 1, parityOk = 1, ninthBit = 0, overrun = 0;
  logic statusRd = 0, dataRd = 0;
  logic idleIn = 0, txEmptyIn = 0, txDoneIn = 0;
  logic rxLoad;
  logic [SW-1:0] statusWord;

  int nChecks = 0;
  int nFails  = 0;

  always #2.5 clk = ~clk;

  rx_status_flags #(.STATUS_W(SW)) u_dut (
    .clk(clk), .rstN(rstN), .softReset(softReset), .unitReset(unitReset),
    .stopCmd(stopCmd), .modeSel(modeSel), .wordValid(wordValid),
    .stopOk(stopOk), .parityOk(parityOk), .ninthBit(ninthBit),
    .overrun(overrun), .statusRd(statusRd), .dataRd(dataRd),
    .idleIn(idleIn), .txEmptyIn(txEmptyIn), .txDoneIn(txDoneIn),
    .rxLoad(rxLoad), .statusWord(statusWord)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [SW-1:0] expWord(input logic r8, fe, pe, ov, full);
    return {{(SW-8){1'b0}}, r8, fe, pe, ov, idleIn, full, txEmptyIn, txDoneIn};
  endfunction

  task automatic checkWord(input string req, input logic r8, fe, pe, ov, full);
    logic [SW-1:0] e;
    e = expWord(r8, fe, pe, ov, full);
    check(statusWord === e, req, int'(statusWord), int'(e));
  endtask

  // one character strobe; returns rxLoad seen mid-cycle
  task automatic sendWord(input logic [1:0] m, input logic s, p, n, o,
                          input logic rd, output logic loadSeen);
    @(negedge clk);
    modeSel = m; stopOk = s; parityOk = p; ninthBit = n; overrun = o;
    wordValid = 1'b1; dataRd = rd;
    #1 loadSeen = rxLoad;
    @(negedge clk);
    wordValid = 1'b0; overrun = 1'b0; dataRd = 1'b0;
  endtask

  task automatic rdStatus;
    @(negedge clk); statusRd = 1'b1;
    @(negedge clk); statusRd = 1'b0;
  endtask

  task automatic rdData;
    @(negedge clk); dataRd = 1'b1;
    @(negedge clk); dataRd = 1'b0;
  endtask

  task automatic pulseReset(input int which);
    @(negedge clk);
    if (which == 0) softReset = 1'b1;
    else if (which == 1) unitReset = 1'b1;
    else stopCmd = 1'b1;
    @(negedge clk);
    softReset = 1'b0; unitReset = 1'b0; stopCmd = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    logic ld;
    repeat (3) @(negedge clk);
    // R1 reset state
    checkWord("R1 reset", 0, 0, 0, 0, 0);
    rstN = 1'b1;
    @(negedge clk);
    checkWord("R1 after release", 0, 0, 0, 0, 0);

    // R2 layout and pass-through of line-state bits
    for (int k = 0; k < 8; k++) begin
      idleIn = k[2]; txEmptyIn = k[1]; txDoneIn = k[0];
      #1 checkWord("R2 line bits", 0, 0, 0, 0, 0);
      @(negedge clk);
    end
    idleIn = 1'b1; txEmptyIn = 1'b0; txDoneIn = 1'b1;

    // sweep every mode and attribute combination
    for (int m = 0; m < 4; m++) begin
      for (int a = 0; a < 8; a++) begin
        logic s, p, n, eFe, ePe, eR8;
        s = a[0]; p = a[1]; n = a[2];
        eFe = (m != 0) && !s;
        ePe = (m == 2) && !p;
        eR8 = (m == 3) && n;
        pulseReset(0);
        sendWord(2'(m), s, p, n, 1'b0, 1'b0, ld);
        check(ld === 1'b1, "R3 load permit", int'(ld), 1);
        checkWord("R3 R4 R5 R6 flags after load", eR8, eFe, ePe, 0, 1);
        rdStatus();
        checkWord("R6 status read keeps flags", eR8, eFe, ePe, 0, 1);
        rdData();
        checkWord("R9 R10 armed data read clears", eR8, 0, 0, 0, 0);
      end
    end

    // R7 FE blocks further loads; PE does not
    pulseReset(1);
    sendWord(2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, ld);
    checkWord("R7 frame error set", 0, 1, 0, 0, 1);
    rdData();
    checkWord("R7 data read empties but keeps FE", 0, 1, 0, 0, 0);
    sendWord(2'd3, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, ld);
    check(ld === 1'b0, "R7 no load while FE", int'(ld), 0);
    checkWord("R7 blocked word changes nothing", 0, 1, 0, 0, 0);
    pulseReset(2);
    sendWord(2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, ld);
    checkWord("R7 parity error set", 0, 0, 1, 0, 1);
    sendWord(2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, ld);
    check(ld === 1'b1, "R7 PE does not block", int'(ld), 1);
    checkWord("R7 second word loaded", 0, 0, 0, 0, 1);

    // R8 overrun hides framing and parity errors
    pulseReset(0);
    sendWord(2'd3, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, ld);
    sendWord(2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, ld);
    check(ld === 1'b0, "R8 overrun not loaded", int'(ld), 0);
    checkWord("R8 only OR raised", 1, 0, 0, 1, 1);
    rdStatus(); rdData();
    checkWord("R8 R9 OR cleared by sequence", 1, 0, 0, 0, 0);

    // R9 data read without prior status read keeps errors; tracker disarms
    pulseReset(0);
    sendWord(2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, ld);
    rdData();
    checkWord("R9 unarmed read keeps FE", 0, 1, 0, 0, 0);
    rdStatus(); rdData();
    checkWord("R9 armed read clears FE", 0, 0, 0, 0, 0);
    sendWord(2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, ld);
    rdData();
    checkWord("R9 tracker disarmed after read", 0, 1, 0, 0, 0);

    // R11 new word in same cycle as clearing read
    pulseReset(0);
    sendWord(2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, ld);
    rdStatus();
    sendWord(2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, ld);
    check(ld === 1'b1, "R11 load beside read", int'(ld), 1);
    checkWord("R11 new word flags win", 0, 0, 1, 0, 1);
    rdData();
    checkWord("R11 tracker was consumed", 0, 0, 1, 0, 0);

    // R12 each synchronous reset source
    for (int w = 0; w < 3; w++) begin
      pulseReset(0);
      sendWord(2'd3, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, ld);
      sendWord(2'd3, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, ld);
      checkWord("R12 flags before reset", 1, 0, 0, 1, 1);
      rdStatus();
      pulseReset(w);
      checkWord("R12 reset source clears", 0, 0, 0, 0, 0);
      sendWord(2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, ld);
      rdData();
      checkWord("R12 tracker cleared", 0, 1, 0, 0, 0);
    end

    // R12 load suppressed during reset pulse
    pulseReset(0);
    @(negedge clk);
    softReset = 1'b1; wordValid = 1'b1; modeSel = 2'd1; stopOk = 1'b1;
    #1 check(rxLoad === 1'b0, "R12 no load during reset", int'(rxLoad), 0);
    @(negedge clk);
    softReset = 1'b0; wordValid = 1'b0;
    checkWord("R12 nothing loaded", 0, 0, 0, 0, 0);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule